// File: doc/BRIEF.md
# GPIO Pin Bank with Interrupt Detection

This block is a bank of general-purpose I/O pins. Each pin is controlled through four 32-bit registers on a simple read/write bus. Through them software sets the pin's output value and output enable, reads the pin level, and picks how the pin raises an interrupt. Drive strength, pull mode and function select are held in register bits and have no other effect inside the block.

Each pin input passes through a two-flop synchronizer. A detector then watches for a level, a rising edge, a falling edge or either edge, and the level case has a selectable active polarity. A trigger has two independent outcomes. The first is a sticky status bit, updated only while status capture is enabled. The second is a contribution to a single registered summary interrupt, made only while the pin's interrupt enable is set and its target field routes it to the application processor. An interrupt can therefore fire while the status bit stays clear. Turning status capture on can record a stale event, so software clears the status after it writes the interrupt configuration.

Top module: `gpio_bank`

## Requirements
- R1: Pin p owns four registers at byte address p*0x10 plus an offset: 0x0 configuration, 0x4 in/out, 0x8 interrupt configuration, 0xC interrupt status. Address bits 1:0 are ignored. `bus_rdata` carries the addressed word in the cycle after `bus_rd` is sampled and is 0 in the cycle after an edge with no read. Unused bits read 0.
- R2: Configuration bits 9:0 are stored and read back: 9 is output enable, 8:6 drive strength, 5:2 function select, 1:0 pull mode. Bit 9 drives `pin_oe[p]`. Bits 31:10 read 0.
- R3: In/out bit 1 is writable and drives `pin_out[p]`. In/out bit 0 is read-only and returns the pin input after a two-flop synchronizer, so a read sampled on the first clock edge after the input changes still returns the old level.
- R4: Interrupt configuration bits 7:0 are stored and read back: bit 0 interrupt enable, bit 1 polarity (1 = active high), bits 3:2 detection type, bit 4 status capture enable, bits 7:5 target (4 = application processor, any other value routes nowhere).
- R5: Detection type 0 is level mode. It triggers while the synchronized input equals the polarity bit.
- R6: Detection type 1 triggers on a rising edge, 2 on a falling edge and 3 on either edge, each for one cycle. In these modes the polarity bit has no effect.
- R7: The status bit (bit 0) is set on a trigger only while capture is enabled, whatever the interrupt enable. Writing a word with bit 0 = 0 clears it, and writing with bit 0 = 1 leaves it unchanged. A trigger in the same cycle as a clear wins.
- R8: `irq_out` is the OR over pins of (status or live trigger) AND enable AND target = 4, registered once. With capture off and enable on, an edge gives exactly one high cycle of `irq_out` while status stays 0.
- R9: Pins are independent. Configuring or triggering one pin does not change another pin's status or outputs.
- R10: After synchronous reset all registers are 0, and `pin_out`, `pin_oe`, `irq_out` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables |
| irq_out | output | 1 | Summary interrupt to the application processor |

## Verification
A wrong detector or synchronizer state shows up at the ports within three clock edges of an input change. The interrupt output either misses its pulse or holds for the wrong number of cycles, and the status word read back on the bus disagrees with the capture enable. A corrupted configuration register is seen at once on `pin_oe` or `pin_out`, or in the word returned one cycle after a read. A status bit that is set or cleared wrongly persists until the next clear write, so a single later read exposes it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

  // Interrupt configuration word, bit 0 is the enable.
  typedef struct packed {
    logic [2:0] target;
    logic       cap_en;
    det_mode_e  mode;
    logic       pol_hi;
    logic       irq_en;
  } icfg_t;

  localparam int ICFG_W = $bits(icfg_t);
  localparam int CFG_W  = 10;
  localparam int OE_BIT = CFG_W - 1;
  localparam int REG_STRIDE_LOG2 = 4;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_IO   = 2'd1;
  localparam logic [1:0] SEL_ICFG = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam logic [2:0] TARGET_APP = 3'd4;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sync_in,
  input  det_mode_e mode,
  input  logic      pol_hi,
  output logic      trig
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_in;
  end

  always_comb begin
    unique case (mode)
      DET_LEVEL: trig = (sync_in == pol_hi);
      DET_RISE:  trig = sync_in & ~prev_q;
      DET_FALL:  trig = ~sync_in & prev_q;
      DET_BOTH:  trig = sync_in ^ prev_q;
      default:   trig = 1'b0;
    endcase
  end

  // A rising-edge trigger never lasts two cycles in a row.
  assert_rise_single_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == DET_RISE && trig) |=> (mode != DET_RISE || !trig));

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pin_sync,
  output logic              oe,
  output logic              out_val,
  output icfg_t             icfg,
  output logic              irq_req,
  output logic [DATA_W-1:0] rd_word
);

  logic [CFG_W-1:0] cfg_q;
  logic             out_q;
  icfg_t            icfg_q;
  logic             status_q;
  logic             trig;
  logic             set_evt;
  logic             clr_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      out_q  <= 1'b0;
      icfg_q <= '0;
    end else if (wr_en) begin
      case (reg_sel)
        SEL_CFG:  cfg_q  <= wdata[CFG_W-1:0];
        SEL_IO:   out_q  <= wdata[1];
        SEL_ICFG: icfg_q <= icfg_t'(wdata[ICFG_W-1:0]);
        default:  ;
      endcase
    end
  end

  gpio_edge_detect u_detect (
    .clk     (clk),
    .rst     (rst),
    .sync_in (pin_sync),
    .mode    (icfg_q.mode),
    .pol_hi  (icfg_q.pol_hi),
    .trig    (trig)
  );

  assign set_evt = trig & icfg_q.cap_en;
  assign clr_evt = wr_en && (reg_sel == SEL_STAT) && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst)          status_q <= 1'b0;
    else if (set_evt) status_q <= 1'b1;
    else if (clr_evt) status_q <= 1'b0;
  end

  assign irq_req = (status_q | trig) & icfg_q.irq_en & (icfg_q.target == TARGET_APP);
  assign oe      = cfg_q[OE_BIT];
  assign out_val = out_q;
  assign icfg    = icfg_q;

  always_comb begin
    rd_word = '0;
    case (reg_sel)
      SEL_CFG:  rd_word[CFG_W-1:0]  = cfg_q;
      SEL_IO:   rd_word[1:0]        = {out_q, pin_sync};
      SEL_ICFG: rd_word[ICFG_W-1:0] = icfg_q;
      default:  rd_word[0]          = status_q;
    endcase
  end

  assert_status_needs_capture_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(icfg_q.cap_en));

  assert_status_clear_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q) |-> $past(clr_evt));

  assert_oe_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && reg_sel == SEL_CFG) |-> $stable(oe));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(NUM_PINS) + REG_STRIDE_LOG2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);

  localparam int IDX_W = ADDR_W - REG_STRIDE_LOG2;

  logic [IDX_W-1:0]    pin_idx;
  logic [1:0]          reg_sel;
  logic                idx_ok;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] irq_req;
  logic [NUM_PINS-1:0] routed;
  logic [DATA_W-1:0]   rd_word [NUM_PINS];
  logic [DATA_W-1:0]   rdata_q;
  logic                irq_q;

  assign pin_idx = bus_addr[ADDR_W-1:REG_STRIDE_LOG2];
  assign reg_sel = bus_addr[3:2];
  assign idx_ok  = ({1'b0, pin_idx} < (IDX_W+1)'(NUM_PINS));

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (pin_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    icfg_t icfg_p;
    logic  wr_p;

    assign wr_p = bus_wr && idx_ok && (pin_idx == IDX_W'(p));

    gpio_pin_ctrl #(.DATA_W(DATA_W)) u_pin (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_p),
      .reg_sel  (reg_sel),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync[p]),
      .oe       (pin_oe[p]),
      .out_val  (pin_out[p]),
      .icfg     (icfg_p),
      .irq_req  (irq_req[p]),
      .rd_word  (rd_word[p])
    );

    assign routed[p] = icfg_p.irq_en && (icfg_p.target == TARGET_APP);
  end

  always_ff @(posedge clk) begin
    if (rst)                   rdata_q <= '0;
    else if (bus_rd && idx_ok) rdata_q <= rd_word[pin_idx];
    else                       rdata_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |irq_req;
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  assert_rdata_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0));

  assert_irq_routed_R8: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|routed));

endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pin_in = '0;
  logic [3:0]  pin_out;
  logic [3:0]  pin_oe;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // Row: {intr cfg[7:0], start level, end level, expected status, expected irq}
  localparam logic [11:0] VEC [0:11] = '{
    {8'h93, 1'b0, 1'b1, 1'b1, 1'b1},  // level, active high
    {8'h91, 1'b1, 1'b0, 1'b1, 1'b1},  // level, active low
    {8'h95, 1'b0, 1'b1, 1'b1, 1'b1},  // rising, edge present
    {8'h95, 1'b1, 1'b0, 1'b0, 1'b0},  // rising, wrong edge
    {8'h99, 1'b1, 1'b0, 1'b1, 1'b1},  // falling
    {8'h99, 1'b0, 1'b1, 1'b0, 1'b0},  // falling, wrong edge
    {8'h9D, 1'b0, 1'b1, 1'b1, 1'b1},  // both, rise
    {8'h9D, 1'b1, 1'b0, 1'b1, 1'b1},  // both, fall
    {8'h85, 1'b0, 1'b1, 1'b0, 1'b0},  // rising, capture off
    {8'h94, 1'b0, 1'b1, 1'b1, 1'b0},  // rising, enable off
    {8'hF5, 1'b0, 1'b1, 1'b1, 1'b0},  // rising, target none
    {8'h83, 1'b0, 1'b1, 1'b0, 1'b1}   // level, capture off: live trigger
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] ad(input int pin, input int off);
    return 6'(pin * 16 + off);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    check("R10 pin_oe", 32'(pin_oe), 0);
    check("R10 pin_out", 32'(pin_out), 0);
    check("R10 irq_out", 32'(irq_out), 0);
    rd(ad(0, 8), d); check("R10 icfg reset", d, 0);
    rd(ad(2, 0), d); check("R10 cfg reset", d, 0);

    // R1, R2 config bits, stride, unused bits
    wr(ad(1, 0), 32'hFFFF_FFFF);
    check("R2 pin_oe", 32'(pin_oe), 32'h2);
    rd(ad(1, 0), d); check("R2 cfg readback", d, 32'h3FF);
    wr(ad(1, 0), 32'h1FF);
    check("R2 oe off", 32'(pin_oe), 0);
    wr(ad(2, 8), 32'h0000_FF25);
    rd(ad(2, 8), d); check("R4 icfg readback", d, 32'h25);
    rd(ad(2, 9), d); check("R1 low bits ignored", d, 32'h25);

    // R3 output and synchronized input
    wr(ad(2, 4), 32'h2);
    check("R3 pin_out", 32'(pin_out), 32'h4);
    rd(ad(2, 4), d); check("R1 io readback", d, 32'h2);
    @(negedge clk);
    pin_in[1] = 1'b1; bus_addr = ad(1, 4); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check("R3 sync delay", bus_rdata, 32'h0);
    idle(2);
    rd(ad(1, 4), d); check("R3 input seen", d, 32'h1);
    pin_in[1] = 1'b0;
    wr(ad(2, 8), 32'h0);

    // Vector table on pin 0 (R5, R6, R7, R8)
    for (int i = 0; i < 12; i++) begin
      logic [7:0] cf;
      string tag;
      cf = VEC[i][11:4];
      tag = (cf[3:2] == 2'd0) ? "R5" : "R6";
      @(negedge clk); pin_in[0] = VEC[i][3];
      idle(4);
      wr(ad(0, 8), {24'h0, cf});
      idle(2);
      wr(ad(0, 12), 32'h0);
      idle(2);
      @(negedge clk); pin_in[0] = VEC[i][2];
      idle(5);
      rd(ad(0, 12), d);
      check($sformatf("%s R7 vec%0d status", tag, i), d, 32'(VEC[i][1]));
      check($sformatf("%s R8 vec%0d irq", tag, i), 32'(irq_out), 32'(VEC[i][0]));
    end

    // R8 single pulse with capture off
    wr(ad(0, 8), 32'h85);
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);
    wr(ad(0, 12), 32'h0);
    @(negedge clk); pin_in[0] = 1'b1;
    begin
      int hi = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (irq_out) hi++;
      end
      check("R8 pulse length", 32'(hi), 1);
    end
    rd(ad(0, 12), d); check("R8 status stays clear", d, 0);

    // R7 write of 1 keeps status; clear loses to active trigger
    wr(ad(0, 8), 32'h93);
    idle(4);
    wr(ad(0, 12), 32'h0);
    rd(ad(0, 12), d); check("R7 set wins over clear", d, 32'h1);
    @(negedge clk); pin_in[0] = 1'b0;
    idle(4);
    wr(ad(0, 12), 32'h1);
    rd(ad(0, 12), d); check("R7 write one keeps", d, 32'h1);
    wr(ad(0, 12), 32'h0);
    rd(ad(0, 12), d); check("R7 write zero clears", d, 32'h0);

    // R9 pin independence
    wr(ad(0, 8), 32'h0);
    wr(ad(3, 8), 32'h93);
    idle(3);
    wr(ad(3, 12), 32'h0);
    @(negedge clk); pin_in[3] = 1'b1;
    idle(5);
    check("R9 pin3 irq", 32'(irq_out), 1);
    rd(ad(3, 12), d); check("R9 pin3 status", d, 32'h1);
    rd(ad(0, 12), d); check("R9 pin0 untouched", d, 32'h0);
    check("R9 outputs untouched", 32'({pin_oe, pin_out}), 32'h04);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule